// File: doc/BRIEF.md
# Serial Result Output Port for a Sampling Converter

This block moves a 16-bit conversion result onto a single serial data line. A conversion is modelled by two strobes: a start strobe and a done strobe that carries the parallel result. On the done strobe the result is stored in output format. The block then sends it MSB first from a shift register.

Master mode uses a data clock and frame sync generated from the system clock. Straps select whether the current result is sent after the conversion or the previous result is sent during it. In slave mode an external clock, gated by chip select, advances the shift register. Data shifted in on the daisy-chain input comes out after the result, so several ports can share one data line. Straps also select the clock edge, the sync polarity and the output code. A busy flag brackets each conversion. In slave mode an error pulse reports a read that was cut off by a new result.

Top module: `adc_serial_port`

## Requirements
- R1: In master mode a frame carries exactly 16 bit periods, result MSB first. SDOUT holds one bit for a whole bit period. Each bit period lasts two half periods. The frame starts on the clock edge of its trigger.
- R2: With `binaryFmt` high the word sent is the result unchanged. With it low, bit 15 of the result is inverted (two's complement).
- R3: In master mode the half period is 2^`clkDiv` system clocks, so the clock divides by 2, 4, 8 or 16. Outside a frame SCLK rests at the level of `invClk`. With `invClk` low, SCLK rises at the start of each bit, where SDOUT changes, and falls mid-bit. With `invClk` high both edges are swapped.
- R4: In master mode SYNC is active for exactly the cycles of the frame and inactive otherwise. The active level is high when `invSync` is low and low when `invSync` is high. In slave mode SYNC stays inactive.
- R5: With `readDuring` low in master mode, the done strobe starts a frame carrying the new result, divided as in R3.
- R6: With `readDuring` high in master mode, the start strobe begins a frame carrying the previously stored result. The half period is one system clock whatever `clkDiv` holds.
- R7: In slave mode the done strobe loads the shift register, and SDOUT shows the MSB. `extSclk` goes through two sampling registers. An active edge (rising when `invClk` low, falling when high) taken while `csN` is low shifts the register on the second system clock edge after it.
- R8: In slave mode each shift takes `sdin` into the LSB. After 16 shifts, the `sdin` level of the first shift appears on SDOUT.
- R9: In slave mode, a done strobe arriving after 1 to 15 shifts since the last load drives `rdError` high for exactly one cycle. A done strobe after 0 or 16 or more shifts does not.
- R10: `busy` goes high the cycle after the start strobe and low the cycle after the done strobe. It is low after reset.
- R11: Unless `csN` and `rdN` are both low, SDOUT is low and SYNC sits at its inactive level.
- R12: In master mode a trigger that arrives while a frame is running is ignored. The running frame keeps its word and clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convStart | input | 1 | Conversion start strobe |
| convDone | input | 1 | Conversion done strobe, qualifies convResult |
| convResult | input | 16 | Parallel conversion result |
| slaveMode | input | 1 | 1: external clock, 0: internal clock |
| readDuring | input | 1 | Master: 1 sends previous result during conversion |
| binaryFmt | input | 1 | 1: straight binary, 0: MSB inverted |
| invClk | input | 1 | Swaps the SCLK edge polarity |
| invSync | input | 1 | 1: SYNC active low |
| clkDiv | input | 2 | Master read-after-convert clock divide code |
| csN | input | 1 | Chip select, active low, gates extSclk |
| rdN | input | 1 | Read enable, active low |
| extSclk | input | 1 | External serial clock (slave) |
| sdin | input | 1 | Daisy-chain data input (slave) |
| sdout | output | 1 | Serial data output |
| sclkOut | output | 1 | Generated serial clock (master) |
| sync | output | 1 | Frame sync |
| busy | output | 1 | Conversion in progress |
| rdError | output | 1 | Incomplete-read pulse (slave) |

## Verification
The bench runs each divide code with both clock and sync polarities. A wrong shift point would shift SDOUT in the middle of a bit. A wrong half-period counter would stretch the frame or cut it short. It sends a second trigger into a running frame. A design that does not block this would restart the frame or reload the word. Read-during mode is run with a non-zero divide code, so a design that honours the code there would run the clock slowly. In slave mode the bench reads well past 16 shifts to expose a lost or misplaced daisy-chain bit. It sends a new result mid-read and another after a full read, so an error pulse that is missing, too long or spurious shows up. Each cycle the outputs are compared against a behavioural model. The model keeps its own elapsed-cycle count and a bit queue, and covers windows with the output disabled.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef struct packed {
    logic latch;    // store the formatted result
    logic loadNew;  // shift register takes the incoming result
    logic loadOld;  // shift register takes the stored result
    logic shift;    // advance the shift register by one bit
  } serStrobe_t;
endpackage

// File: rtl/ser_datapath.sv
module ser_datapath
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  input  logic              binaryFmt,
  input  logic [DATA_W-1:0] convResult,
  input  logic              sdinBit,
  output logic              msbOut
);
  logic [DATA_W-1:0] fmtWord;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] shiftQ;

  // two's complement is the straight code with the top bit flipped
  assign fmtWord = binaryFmt ? convResult
                             : {~convResult[DATA_W-1], convResult[DATA_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      shiftQ  <= '0;
    end else begin
      if (strb.latch) resultQ <= fmtWord;
      if (strb.loadNew)      shiftQ <= fmtWord;
      else if (strb.loadOld) shiftQ <= resultQ;
      else if (strb.shift)   shiftQ <= {shiftQ[DATA_W-2:0], sdinBit};
    end
  end

  assign msbOut = shiftQ[DATA_W-1];
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             convDone,
  input  logic             slaveMode,
  input  logic             readDuring,
  input  logic             invClk,
  input  logic             csN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             extSclk,
  output serStrobe_t       strb,
  output logic             frameActive,
  output logic             sclkRaw,
  output logic             busy,
  output logic             rdError
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = (1 << DIV_W) - 1;   // holds 2^maxcode - 1
  localparam int SCNT_W = $clog2(DATA_W + 1);

  logic [HALF_W-1:0] halfCnt, halfLast;
  logic [DIV_W-1:0]  divQ;
  logic              phaseQ;
  logic [CNT_W-1:0]  bitIdx;
  logic              masterStart, halfEnd, bitEnd;
  logic              sclkQ, sclkQQ, slaveEdge;
  logic [SCNT_W-1:0] sCnt;

  assign halfLast    = HALF_W'((1 << divQ) - 1);
  assign masterStart = !slaveMode && !frameActive &&
                       (readDuring ? convStart : convDone);
  assign halfEnd     = frameActive && (halfCnt == halfLast);
  assign bitEnd      = halfEnd && phaseQ;
  assign slaveEdge   = slaveMode && !csN &&
                       (sclkQ ^ invClk) && !(sclkQQ ^ invClk);

  always_comb begin
    strb.latch   = convDone;
    strb.loadNew = (slaveMode && convDone) || (masterStart && !readDuring);
    strb.loadOld = masterStart && readDuring;
    strb.shift   = bitEnd || (slaveEdge && !convDone);
  end

  // master frame timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      halfCnt     <= '0;
      phaseQ      <= 1'b0;
      bitIdx      <= '0;
      divQ        <= '0;
    end else if (masterStart) begin
      frameActive <= 1'b1;
      halfCnt     <= '0;
      phaseQ      <= 1'b0;
      bitIdx      <= '0;
      divQ        <= readDuring ? '0 : clkDiv;
    end else if (frameActive) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (phaseQ) begin
          phaseQ <= 1'b0;
          if (bitIdx == CNT_W'(DATA_W - 1)) frameActive <= 1'b0;
          else                               bitIdx <= bitIdx + 1'b1;
        end else begin
          phaseQ <= 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // slave clock sampling, read progress and error pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      sclkQQ  <= 1'b0;
      sCnt    <= '0;
      rdError <= 1'b0;
    end else begin
      sclkQ   <= extSclk;
      sclkQQ  <= sclkQ;
      rdError <= slaveMode && convDone && (sCnt != '0) &&
                 (sCnt < SCNT_W'(DATA_W));
      if (slaveMode && convDone)
        sCnt <= '0;
      else if (slaveEdge && (sCnt < SCNT_W'(DATA_W)))
        sCnt <= sCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busy <= 1'b0;
    else if (convStart) busy <= 1'b1;
    else if (convDone)  busy <= 1'b0;
  end

  assign sclkRaw = frameActive && !phaseQ;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  input  logic              slaveMode,
  input  logic              readDuring,
  input  logic              binaryFmt,
  input  logic              invClk,
  input  logic              invSync,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              csN,
  input  logic              rdN,
  input  logic              extSclk,
  input  logic              sdin,
  output logic              sdout,
  output logic              sclkOut,
  output logic              sync,
  output logic              busy,
  output logic              rdError
);
  serStrobe_t strb;
  logic       frameActive, sclkRaw, msbOut, outEn;

  ser_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .slaveMode(slaveMode), .readDuring(readDuring), .invClk(invClk),
    .csN(csN), .clkDiv(clkDiv), .extSclk(extSclk), .strb(strb),
    .frameActive(frameActive), .sclkRaw(sclkRaw), .busy(busy),
    .rdError(rdError)
  );

  ser_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .binaryFmt(binaryFmt),
    .convResult(convResult), .sdinBit(slaveMode && sdin), .msbOut(msbOut)
  );

  assign outEn   = !csN && !rdN;
  assign sdout   = outEn && msbOut && (slaveMode || frameActive);
  assign sync    = slaveMode ? invSync : ((outEn && frameActive) ^ invSync);
  assign sclkOut = slaveMode ? invClk : (sclkRaw ^ invClk);
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic convDone,
  input logic slaveMode,
  input logic invClk,
  input logic invSync,
  input logic csN,
  input logic rdN,
  input logic sdout,
  input logic sclkOut,
  input logic sync,
  input logic busy,
  input logic rdError
);
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> busy);
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !convStart) |=> !busy);
  assert_rderr_slave_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdError |-> $past(slaveMode));
  assert_rderr_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdError |=> !rdError);
  assert_idle_out_R11: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (!sdout && (sync == invSync)));
  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !csN && !rdN && (sync == invSync)) |-> (sclkOut == invClk));
  assert_slave_nosync_R4: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (sync == invSync));
endmodule

bind adc_serial_port adc_serial_port_chk i_chk (.*);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 0, convDone = 0;
  logic [15:0] convResult = '0;
  logic        slaveMode = 0, readDuring = 0, binaryFmt = 1;
  logic        invClk = 0, invSync = 0;
  logic [1:0]  clkDiv = '0;
  logic        csN = 0, rdN = 0, extSclk = 0, sdin = 0;
  wire         sdout, sclkOut, sync, busy, rdError;

  int testsRun = 0, testsFailed = 0;
  string curReq = "R10";
  bit started = 0, finished = 0;

  always #5 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convResult(convResult), .slaveMode(slaveMode), .readDuring(readDuring),
    .binaryFmt(binaryFmt), .invClk(invClk), .invSync(invSync),
    .clkDiv(clkDiv), .csN(csN), .rdN(rdN), .extSclk(extSclk), .sdin(sdin),
    .sdout(sdout), .sclkOut(sclkOut), .sync(sync), .busy(busy),
    .rdError(rdError)
  );

  // ---------------- behavioural reference model ----------------
  bit          mBusy, mErr, mActive, s1, s2;
  int          mElapsed, mHalf, sShifts;
  logic [15:0] mWord, mRes;
  bit          bitsQ[$];

  function automatic logic [15:0] fmt(input logic [15:0] v);
    return binaryFmt ? v : (v ^ 16'h8000);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mErr = 0; mActive = 0; mElapsed = 0; mHalf = 1;
      mWord = '0; mRes = '0; s1 = 0; s2 = 0; sShifts = 0;
      bitsQ.delete();
      for (int i = 0; i < 16; i++) bitsQ.push_back(1'b0);
    end else begin
      bit oldActive, edgeSeen;
      oldActive = mActive;
      edgeSeen  = slaveMode && !csN && (s1 ^ invClk) && !(s2 ^ invClk);
      s2 = s1; s1 = extSclk;
      mErr = 0;
      if (mActive) begin
        mElapsed++;
        if (mElapsed == 32 * mHalf) mActive = 0;
      end
      if (slaveMode) begin
        if (convDone) begin
          mErr = (sShifts >= 1 && sShifts <= 15);
          bitsQ.delete();
          for (int i = 15; i >= 0; i--) bitsQ.push_back(fmt(convResult)[i]);
          sShifts = 0;
        end else if (edgeSeen) begin
          void'(bitsQ.pop_front());
          bitsQ.push_back(sdin);
          sShifts++;
        end
      end else if (!oldActive && (readDuring ? convStart : convDone)) begin
        mActive = 1; mElapsed = 0;
        mHalf = readDuring ? 1 : (1 << clkDiv);
        mWord = readDuring ? mRes : fmt(convResult);
      end
      if (convDone) mRes = fmt(convResult);
      if (convStart) mBusy = 1;
      else if (convDone) mBusy = 0;
      started = 1;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d at %0t",
               curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      bit en, raw, expSd, expSync, expSclk;
      int bIdx;
      en = !csN && !rdN;
      if (slaveMode) begin
        expSd = en && bitsQ[0];
        expSync = invSync;
        expSclk = invClk;
      end else begin
        bIdx = mElapsed / (2 * mHalf);
        raw  = mActive && ((mElapsed % (2 * mHalf)) < mHalf);
        expSd = en && mActive && mWord[15 - bIdx];
        expSync = (en && mActive) ^ invSync;
        expSclk = raw ^ invClk;
      end
      check("sdout", sdout, expSd);
      check("sync", sync, expSync);
      check("sclkOut", sclkOut, expSclk);
      check("busy", busy, mBusy);
      check("rdError", rdError, mErr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic startConv();
    convStart = 1; cyc(1); convStart = 0;
  endtask

  task automatic doneConv(input logic [15:0] v);
    convResult = v; convDone = 1; cyc(1); convDone = 0;
  endtask

  task automatic extHalf();
    extSclk = ~extSclk; cyc(3);
  endtask

  task automatic slavePeriods(input int n, input logic [15:0] pat);
    for (int i = 0; i < n; i++) begin
      sdin = pat[15 - (i % 16)];
      extHalf(); extHalf();
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    #2;
    curReq = "R10"; cyc(3);              // reset state compared each cycle
    rstN = 1; cyc(2);

    curReq = "R1";                        // master, read after convert, /2
    startConv(); cyc(4); doneConv(16'hA5C3); cyc(40);

    curReq = "R2";                        // MSB inverted format
    binaryFmt = 0;
    startConv(); cyc(3); doneConv(16'h1234); cyc(40);
    startConv(); cyc(3); doneConv(16'h8001); cyc(40);
    binaryFmt = 1;

    curReq = "R3";                        // divide codes, inverted clock
    invClk = 1; clkDiv = 2'd1;
    startConv(); cyc(2); doneConv(16'h0F0F); cyc(140);
    clkDiv = 2'd2;
    startConv(); cyc(2); doneConv(16'hF00D); cyc(270);

    curReq = "R4";                        // active-low sync
    invSync = 1; invClk = 0; clkDiv = 2'd3;
    startConv(); cyc(2); doneConv(16'h6B29);
    curReq = "R12";                       // re-trigger inside a frame
    cyc(100); startConv(); cyc(2); doneConv(16'hFFFF);
    curReq = "R5"; cyc(420);
    invSync = 0;

    curReq = "R6";                        // read during convert, code ignored
    readDuring = 1; clkDiv = 2'd3;
    startConv(); cyc(5); doneConv(16'h3C5A); cyc(40);
    startConv(); cyc(5); doneConv(16'h0001); cyc(40);
    readDuring = 0; clkDiv = 2'd0;

    curReq = "R11";                       // output disable mid-frame
    startConv(); cyc(2); doneConv(16'hBEEF); cyc(6);
    csN = 1; cyc(8); csN = 0; rdN = 1; cyc(6); rdN = 0; cyc(20);

    rstN = 0; cyc(2); slaveMode = 1; rstN = 1; cyc(2);
    curReq = "R7";
    startConv(); cyc(2); doneConv(16'hC3A5); cyc(2);
    slavePeriods(16, 16'h5A0F);
    curReq = "R8";
    slavePeriods(20, 16'h1357);
    curReq = "R7";                        // inverted edge, csN gating
    invClk = 1; cyc(2);
    doneConv(16'h2468); cyc(2);
    slavePeriods(6, 16'hFFFF);
    csN = 1; slavePeriods(4, 16'h0000); csN = 0;
    slavePeriods(4, 16'hAAAA);
    invClk = 0; extSclk = 0; cyc(3);
    curReq = "R9";                        // cut-off read, then complete read
    doneConv(16'h7777); cyc(2);
    slavePeriods(5, 16'h0000);
    doneConv(16'h1111); cyc(3);
    slavePeriods(16, 16'hC001);
    doneConv(16'h2222); cyc(3);
    doneConv(16'h3333); cyc(3);
    slavePeriods(3, 16'h0000);
    cyc(5);

    finished = 1;
    report();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      testsFailed++;
      $display("[TB] FAIL %s watchdog: actual 0 expected 1 (run ended)", curReq);
      report();
      $finish;
    end
  end
endmodule